// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a simple host request port and a single-data-rate SDRAM device. After reset it runs the power-up sequence on its own. It holds NOP for a programmable settling time, precharges all banks, issues two auto-refresh commands and then writes the mode register. The mode word carries the CAS latency, which is chosen at run time by an input pin, a burst length of one and sequential wrap.

Once initialisation is complete, the host presents a request with a bank, row and column address and a write flag. The sequencer opens the row with ACTIVE and waits tRCD. It then issues a single READ or WRITE with auto-precharge requested on A10, and waits out the recovery time before it accepts the next request. Read data is captured from the data bus exactly CAS-latency cycles after the READ and is handed back with a one-cycle valid strobe.

A refresh interval timer raises a pending flag every REFI_CYCLES clocks. A pending refresh is served as soon as the current access has ended, ahead of any waiting request. Every timing constraint (tRCD, tRP, tRC, tWR, mode-set delay) is a cycle-count parameter and must be at least 2. The column width must not exceed 10 bits.

FSM states: ST_POWERUP (settling count), ST_PRE_ALL, ST_INIT_REF_A, ST_INIT_REF_B, ST_LOAD_MODE, ST_IDLE, ST_AUTO_REF, ST_ACTIVATE, ST_ACCESS, and ST_WAIT. ST_WAIT is a shared countdown that returns to a stored state. The transitions are:
- ST_POWERUP goes to ST_PRE_ALL when the count ends.
- Each command state goes to ST_WAIT, with its successor stored as the return state.
- ST_WAIT goes to the stored state when its count reaches zero.
- ST_IDLE goes to ST_AUTO_REF when a refresh is pending, otherwise to ST_ACTIVATE when a request is valid.
- The return states are: ST_PRE_ALL returns to ST_INIT_REF_A, ST_INIT_REF_A to ST_INIT_REF_B, ST_INIT_REF_B to ST_LOAD_MODE, ST_LOAD_MODE to ST_IDLE, ST_AUTO_REF to ST_IDLE, ST_ACTIVATE to ST_ACCESS, and ST_ACCESS to ST_IDLE.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: From reset until the settling count ends, the command pins carry NOP, CKE is high, init_done is low and req_ready is low even when req_valid is high.
- R2: Initialisation issues, in this order, PRECHARGE with A10 high, AUTO REFRESH, AUTO REFRESH, then MODE REGISTER SET. The commands are spaced by at least tRP, tRC and tRC. The mode word is A[6:4] = latency (3'b010 for 2, 3'b011 for 3) with all other address bits zero. No ACTIVE, READ or WRITE appears before init_done.
- R3: The cycle right after MODE REGISTER SET is a NOP. init_done rises after it and stays high until reset.
- R4: Commands use {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, MODE REGISTER SET 0000. No other code is driven.
- R5: An access issues ACTIVE with BA = req_addr bank field (top 2 bits) and A = row field (middle 12 bits). After at least tRCD cycles it issues READ or WRITE to the same bank with A[COL_W-1:0] = column field (low COL_W bits) and A10 high.
- R6: sd_dq_oe is high only in the WRITE command cycle, and sd_dq_out then equals the request's write data.
- R7: rd_data is the bus value sampled CL rising edges after the READ edge. rd_valid is a one-cycle pulse in the cycle following that edge.
- R8: The next ACTIVE or REFRESH waits at least tWR+tRP after a WRITE and at least CL+tRP after a READ. Two ACTIVE commands are at least tRC apart.
- R9: After init a refresh is requested every REFI_CYCLES cycles and issued as soon as any running access ends. A pending refresh wins over a waiting request, so the gap between refreshes stays within REFI_CYCLES plus one access.
- R10: No command other than NOP is issued within tRC cycles after an AUTO REFRESH.
- R11: The CAS latency is taken from cl3_sel (1 means 3, 0 means 2) when the mode register is written. Later changes of cl3_sel have no effect on read latency until the next reset.
- R12: req_ready is a one-cycle accept pulse. It is given only while req_valid is high, init_done is high, the sequencer is idle and no refresh is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cl3_sel | input | 1 | CAS latency select: 1 = 3, 0 = 2 |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BANK_W+ROW_W+COL_W | {bank, row, column} |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Captured read data |
| init_done | output | 1 | Initialisation complete |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_a | output | A_W | Row/column/mode address |
| sd_dq_out | output | DW | Write data to the bus |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | DW | Read data from the bus |

## Verification
The bound checker watches the local, cycle-to-cycle rules on every cycle:
- A NOP follows mode set.
- Only NOPs follow an AUTO REFRESH for the next cycle.
- A10 is high on every READ and WRITE.
- Data drive happens only with WRITE.
- rd_valid and req_ready are single pulses.
- No access occurs before init_done.

Multi-cycle spacing (tRCD, tRC, tRP, write recovery), the init order, refresh intervals under traffic, latency selection and read-back data can only be shown by the bench's memory model and scenarios. The bench sweeps every bank over edge rows and columns at both latencies.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Sequencer states
    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_PRE_ALL,
        ST_INIT_REF_A,
        ST_INIT_REF_B,
        ST_LOAD_MODE,
        ST_IDLE,
        ST_AUTO_REF,
        ST_ACTIVATE,
        ST_ACCESS,
        ST_WAIT
    } seq_state_t;

    // Command code on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_t;

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int REFI_CYCLES = 3900,
    localparam int CNT_W = $clog2(REFI_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack,
    output logic pending
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            if (ack)
                pending <= 1'b0;
            if (!enable) begin
                cnt <= '0;
            end else if (cnt == CNT_W'(REFI_CYCLES - 1)) begin
                cnt     <= '0;
                pending <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdram_read_capture.sv
module sdram_read_capture #(
    parameter int DW     = 16,
    parameter int MAX_CL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_rd,
    input  logic          cl3,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic [MAX_CL-1:0] pipe;
    logic              tap;

    // pipe[k] is high in the cycle after the (k)-th edge past the READ edge
    assign tap = cl3 ? pipe[2] : pipe[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            pipe     <= {pipe[MAX_CL-2:0], issue_rd};
            rd_valid <= tap;
            if (tap)
                rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int DW          = 16,
    parameter int BANK_W      = 2,
    parameter int ROW_W       = 12,
    parameter int COL_W       = 9,
    parameter int A_W         = 12,
    parameter int INIT_CYCLES = 50000,
    parameter int REFI_CYCLES = 3900,
    parameter int T_RCD       = 3,
    parameter int T_RP        = 3,
    parameter int T_RC        = 9,
    parameter int T_WR        = 2,
    parameter int T_MRD       = 2,
    localparam int ADDR_W     = BANK_W + ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cl3_sel,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              init_done,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [A_W-1:0]    sd_a,
    output logic [DW-1:0]     sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DW-1:0]     sd_dq_in
);
    localparam int WAIT_W  = $clog2(INIT_CYCLES + T_RC + T_WR + T_RP + 8);
    localparam int WR_POST = T_WR + T_RP;
    localparam int RC_POST = T_RC - T_RCD;

    seq_state_t          state, ret_state;
    logic [WAIT_W-1:0]   wait_cnt, post_len;
    logic                cl3_q, init_q, ref_pending, ref_ack;
    logic                lat_write;
    logic [BANK_W-1:0]   lat_bank;
    logic [ROW_W-1:0]    lat_row;
    logic [COL_W-1:0]    lat_col;
    logic [DW-1:0]       lat_wdata;
    sd_cmd_t             cmd;

    // Recovery after the column command: data path, precharge and row cycle
    always_comb begin
        if (lat_write)
            post_len = WAIT_W'(WR_POST);
        else if (cl3_q)
            post_len = WAIT_W'(T_RP + 3);
        else
            post_len = WAIT_W'(T_RP + 2);
        if (post_len < WAIT_W'(RC_POST))
            post_len = WAIT_W'(RC_POST);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_POWERUP;
            ret_state <= ST_IDLE;
            wait_cnt  <= WAIT_W'(INIT_CYCLES - 1);
            cl3_q     <= 1'b0;
            init_q    <= 1'b0;
            lat_write <= 1'b0;
            lat_bank  <= '0;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_wdata <= '0;
        end else begin
            unique case (state)
                ST_POWERUP: begin
                    if (wait_cnt == '0) state <= ST_PRE_ALL;
                    else                wait_cnt <= wait_cnt - 1'b1;
                end
                ST_PRE_ALL: begin
                    state     <= ST_WAIT;
                    ret_state <= ST_INIT_REF_A;
                    wait_cnt  <= WAIT_W'(T_RP - 2);
                end
                ST_INIT_REF_A: begin
                    state     <= ST_WAIT;
                    ret_state <= ST_INIT_REF_B;
                    wait_cnt  <= WAIT_W'(T_RC - 2);
                end
                ST_INIT_REF_B: begin
                    state     <= ST_WAIT;
                    ret_state <= ST_LOAD_MODE;
                    wait_cnt  <= WAIT_W'(T_RC - 2);
                end
                ST_LOAD_MODE: begin
                    cl3_q     <= cl3_sel;
                    init_q    <= 1'b1;
                    state     <= ST_WAIT;
                    ret_state <= ST_IDLE;
                    wait_cnt  <= WAIT_W'(T_MRD - 2);
                end
                ST_IDLE: begin
                    if (ref_pending) begin
                        state <= ST_AUTO_REF;
                    end else if (req_valid) begin
                        lat_write <= req_write;
                        lat_bank  <= req_addr[ADDR_W-1 -: BANK_W];
                        lat_row   <= req_addr[COL_W +: ROW_W];
                        lat_col   <= req_addr[COL_W-1:0];
                        lat_wdata <= req_wdata;
                        state     <= ST_ACTIVATE;
                    end
                end
                ST_AUTO_REF: begin
                    state     <= ST_WAIT;
                    ret_state <= ST_IDLE;
                    wait_cnt  <= WAIT_W'(T_RC - 2);
                end
                ST_ACTIVATE: begin
                    state     <= ST_WAIT;
                    ret_state <= ST_ACCESS;
                    wait_cnt  <= WAIT_W'(T_RCD - 2);
                end
                ST_ACCESS: begin
                    state     <= ST_WAIT;
                    ret_state <= ST_IDLE;
                    wait_cnt  <= post_len - WAIT_W'(2);
                end
                ST_WAIT: begin
                    if (wait_cnt == '0) state <= ret_state;
                    else                wait_cnt <= wait_cnt - 1'b1;
                end
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        cmd       = CMD_NOP;
        sd_ba     = '0;
        sd_a      = '0;
        sd_dq_oe  = 1'b0;
        sd_dq_out = '0;
        unique case (state)
            ST_PRE_ALL: begin
                cmd      = CMD_PRE;
                sd_a[10] = 1'b1;
            end
            ST_INIT_REF_A, ST_INIT_REF_B, ST_AUTO_REF: cmd = CMD_REF;
            ST_LOAD_MODE: begin
                cmd       = CMD_MRS;
                sd_a[6:4] = cl3_sel ? 3'b011 : 3'b010;
            end
            ST_ACTIVATE: begin
                cmd                = CMD_ACT;
                sd_ba              = lat_bank;
                sd_a[ROW_W-1:0]    = lat_row;
            end
            ST_ACCESS: begin
                cmd                = lat_write ? CMD_WR : CMD_RD;
                sd_ba              = lat_bank;
                sd_a[COL_W-1:0]    = lat_col;
                sd_a[10]           = 1'b1;
                sd_dq_oe           = lat_write;
                sd_dq_out          = lat_write ? lat_wdata : '0;
            end
            default: ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke    = 1'b1;
    assign init_done = init_q;
    assign req_ready = (state == ST_IDLE) && !ref_pending && req_valid;
    assign ref_ack   = (state == ST_AUTO_REF);

    sdram_refresh_timer #(
        .REFI_CYCLES(REFI_CYCLES)
    ) refresh_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (init_q),
        .ack    (ref_ack),
        .pending(ref_pending)
    );

    sdram_read_capture #(
        .DW    (DW),
        .MAX_CL(3)
    ) capture_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_rd((state == ST_ACCESS) && !lat_write),
        .cl3     (cl3_q),
        .dq_in   (sd_dq_in),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
    parameter int A_W = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic           rd_valid,
    input logic           init_done,
    input logic           sd_cs_n,
    input logic           sd_ras_n,
    input logic           sd_cas_n,
    input logic           sd_we_n,
    input logic [A_W-1:0] sd_a,
    input logic           sd_dq_oe
);
    logic [3:0] pin_cmd;
    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    assert_nop_after_mrs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_cmd == 4'b0000 |=> pin_cmd == 4'b0111);

    assert_init_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_autopre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0101 || pin_cmd == 4'b0100) |-> sd_a[10]);

    assert_drive_only_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> pin_cmd == 4'b0100);

    assert_rdvalid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_nop_after_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_cmd == 4'b0001 |=> pin_cmd == 4'b0111);

    assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_ready_qualified_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (req_valid && init_done));

    assert_no_access_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !(pin_cmd == 4'b0011 || pin_cmd == 4'b0101 || pin_cmd == 4'b0100));
endmodule

bind sdram_seq_ctrl sdram_seq_chk #(.A_W(A_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .init_done(init_done),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_a     (sd_a),
    .sd_dq_oe (sd_dq_oe)
);

// File: tb/sdram_seq_ctrl_tb_top.sv
module sdram_seq_ctrl_tb_top;
    localparam int DW = 16, BANK_W = 2, ROW_W = 12, COL_W = 9, A_W = 12;
    localparam int INIT_C = 40, REFI = 150;
    localparam int TRCD = 3, TRP = 3, TRC = 8, TWR = 2, TMRD = 2;
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;

    localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101,
                           K_WR = 4'b0100, K_PRE = 4'b0010, K_REF = 4'b0001, K_MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              cl3_sel, req_valid, req_write, req_ready, rd_valid, init_done;
    logic [ADDR_W-1:0] req_addr;
    logic [DW-1:0]     req_wdata, rd_data, sd_dq_out, sd_dq_in;
    logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [BANK_W-1:0] sd_ba;
    logic [A_W-1:0]    sd_a;

    sdram_seq_ctrl #(
        .DW(DW), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W),
        .INIT_CYCLES(INIT_C), .REFI_CYCLES(REFI),
        .T_RCD(TRCD), .T_RP(TRP), .T_RC(TRC), .T_WR(TWR), .T_MRD(TMRD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cl3_sel(cl3_sel),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .init_done(init_done),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int b, input int r, input int c, input int cl);
        return 16'(b * 7919 + r * 131 + c * 3 + cl * 4099);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: samples the command in mid-cycle, checks spacing rules
    logic [3:0]  m_cmd;
    logic [15:0] mem [int];
    logic [15:0] due_data;
    int init_step, ready_cyc, rcd_ok, last_act, last_ref, model_cl;
    int due_cyc, ref_count, last_rd_cyc, act_bank, act_row, key, init_cl;
    bit prev_mrs;

    always @(negedge clk) begin
        m_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (!rst_n) begin
            init_step = 0; ready_cyc = 0; rcd_ok = 0; last_act = -1000;
            last_ref = -1000; due_cyc = -1; ref_count = 0; prev_mrs = 0;
            model_cl = 2; sd_dq_in = '0;
        end else begin
            sd_dq_in = (cyc == due_cyc) ? due_data : 16'h0;
            if (prev_mrs) chk(m_cmd == K_NOP, "R3", "cycle after mode set", m_cmd, K_NOP);
            prev_mrs = (m_cmd == K_MRS);
            if (m_cmd != K_NOP)
                chk(cyc - last_ref >= TRC, "R10", "gap after refresh", cyc - last_ref, TRC);
            if (m_cmd == K_REF || m_cmd == K_MRS || m_cmd == K_ACT)
                chk(cyc >= ready_cyc, (init_step < 4) ? "R2" : "R8", "command spacing", cyc, ready_cyc);
            case (m_cmd)
                K_NOP: ;
                K_PRE: begin
                    chk(init_step == 0, "R2", "precharge position", init_step, 0);
                    chk(sd_a[10], "R2", "A10 on precharge all", sd_a[10], 1);
                    init_step++; ready_cyc = cyc + TRP;
                end
                K_REF: begin
                    if (init_step < 4) begin
                        chk(init_step == 1 || init_step == 2, "R2", "refresh position", init_step, 1);
                        init_step++;
                    end else begin
                        chk(cyc - last_ref <= REFI + 2 * TRC + 12, "R9", "refresh interval",
                            cyc - last_ref, REFI);
                        ref_count++;
                    end
                    last_ref = cyc; ready_cyc = cyc + TRC;
                end
                K_MRS: begin
                    chk(init_step == 3, "R2", "mode set position", init_step, 3);
                    chk(sd_a == A_W'(init_cl << 4), "R2", "mode word", sd_a, init_cl << 4);
                    model_cl = int'(sd_a[6:4]); init_step = 4; ready_cyc = cyc + TMRD;
                end
                K_ACT: begin
                    chk(init_step == 4, "R2", "activate before init", init_step, 4);
                    chk(cyc - last_act >= TRC, "R8", "activate to activate", cyc - last_act, TRC);
                    last_act = cyc; act_bank = int'(sd_ba); act_row = int'(sd_a);
                    rcd_ok = cyc + TRCD;
                end
                K_RD, K_WR: begin
                    chk(cyc >= rcd_ok, "R5", "activate to column", cyc, rcd_ok);
                    chk(sd_a[10], "R5", "auto-precharge flag", sd_a[10], 1);
                    chk(int'(sd_ba) == act_bank, "R5", "column bank", sd_ba, act_bank);
                    key = (act_bank << 21) | (act_row << 9) | int'(sd_a[COL_W-1:0]);
                    if (m_cmd == K_WR) begin
                        chk(sd_dq_oe, "R6", "write drive enable", sd_dq_oe, 1);
                        mem[key] = sd_dq_out;
                        ready_cyc = cyc + TWR + TRP;
                    end else begin
                        due_cyc = cyc + model_cl;
                        due_data = mem.exists(key) ? mem[key] : 16'hBAD0;
                        last_rd_cyc = cyc;
                        ready_cyc = cyc + model_cl + TRP;
                    end
                end
                default: chk(0, "R4", "illegal command code", m_cmd, K_NOP);
            endcase
        end
    end

    task automatic host_req(input bit wr, input int b, input int r, input int c, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wdata = d;
        req_addr = {b[1:0], r[11:0], c[8:0]};
        while (1) begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic host_read(input int b, input int r, input int c, input logic [15:0] exp);
        host_req(1'b0, b, r, c, 16'h0);
        while (!rd_valid) @(negedge clk);
        chk(rd_data == exp, "R7", "read data", rd_data, exp);
        // R11: latency is the one programmed at init, not the current pin
        chk(cyc == last_rd_cyc + init_cl + 1, "R11", "read latency", cyc - last_rd_cyc, init_cl + 1);
        @(negedge clk);
        chk(!rd_valid, "R7", "valid pulse width", rd_valid, 0);
    endtask

    int rows[3] = '{0, 1, 4095};
    int cols[3] = '{0, 1, 511};

    initial begin
        cl3_sel = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; init_cl = 2;
        for (int pass = 0; pass < 2; pass++) begin
            init_cl = (pass == 0) ? 2 : 3;
            cl3_sel = (init_cl == 3);
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            req_valid = 1'b1; req_write = 1'b1;
            repeat (INIT_C - 5) begin
                @(negedge clk);
                chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == K_NOP && sd_cke && !init_done,
                    "R1", "power-up idle pins", {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'b10111);
                chk(!req_ready, "R12", "ready during power-up", req_ready, 0);
            end
            req_valid = 1'b0;
            while (!init_done) @(negedge clk);
            chk(init_step == 4, "R2", "init sequence complete", init_step, 4);
            cl3_sel = ~cl3_sel;
            for (int b = 0; b < 4; b++)
                for (int ri = 0; ri < 3; ri++)
                    for (int ci = 0; ci < 3; ci++)
                        host_req(1'b1, b, rows[ri], cols[ci], pat(b, rows[ri], cols[ci], init_cl));
            for (int b = 0; b < 4; b++)
                for (int ri = 0; ri < 3; ri++)
                    for (int ci = 0; ci < 3; ci++)
                        host_read(b, rows[ri], cols[ci], pat(b, rows[ri], cols[ci], init_cl));
            begin
                int rc0;
                rc0 = ref_count;
                repeat (REFI * 3) @(negedge clk);
                chk(ref_count - rc0 >= 2, "R9", "idle refreshes", ref_count - rc0, 2);
            end
            chk(ref_count >= 4, "R9", "refreshes under traffic", ref_count, 4);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule